// File: doc/BRIEF.md
# Auto-negotiation expansion status register

This block holds the auto-negotiation expansion status word of an Ethernet PHY's management register file, at management index 6. The auto-negotiation logic feeds it single-cycle event pulses and one level input. These are a parallel detection fault, a new link code word stored in the partner ability register, the next-page bit carried by that code word, and the arrival of valid fast link pulse bursts. The block turns them into status bits that management software reads.

Two bits latch high. An event sets them, and they stay at one until this register is read. A read returns the value the bits held before that read and clears them. If a fresh event lands in the same cycle as the clearing read, the event wins and the bit stays set. One bit is a constant local capability flag. The partner next-page bit follows the most recently stored code word. The partner auto-negotiation-able bit stays set once bursts have been seen. The management read port is a plain strobe with an address, and the read data appears one cycle later. A restart of auto-negotiation wipes all the state gathered from the partner.

Top module: `anx_status_reg`

## Requirements
- R1: When rd_en is high with rd_addr equal to 6 in cycle t, rd_data in cycle t+1 equals the register value held before the edge that ends cycle t. Any other cycle, including a strobe with a different address, gives rd_data equal to zero in the next cycle.
- R2: Bits 15 to 5 of every read of index 6 are zero.
- R3: Bit 2 (local next-page capable) always reads as one with the default parameters, including after a reset or a restart.
- R4: A one-cycle pulse on fault_evt sets bit 4. Bit 4 stays at one through idle cycles and through reads of other addresses. The first read of index 6 returns it as one and clears it, so the next read returns zero.
- R5: A one-cycle pulse on page_evt sets bit 1, with the same hold-until-read and clear-on-read behaviour as bit 4.
- R6: Bit 3 takes the value of lp_np_bit in each cycle where page_evt is high. It holds that value otherwise, and a read does not clear it.
- R7: A pulse on flp_evt sets bit 0. Bit 0 stays at one across reads and clears only on restart or reset.
- R8: A fault_evt or page_evt pulse in the same cycle as a read of index 6 is not lost. That read returns the prior value of the bit, and the bit remains one for the following read.
- R9: An an_restart pulse clears bits 4, 3, 1 and 0, and it takes priority over any event in the same cycle. Bit 2 is unchanged. A read in the restart cycle returns the pre-restart value.
- R10: While rst is high, rd_data is zero. After reset, bits 4, 3, 1 and 0 read as zero, so the first read of index 6 returns 0x0004.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| an_restart | input | 1 | Auto-negotiation restart pulse; clears partner-derived bits |
| rd_en | input | 1 | Management read strobe |
| rd_addr | input | 5 | Management register index of the read |
| rd_data | output | 16 | Read data, valid the cycle after the strobe; zero otherwise |
| fault_evt | input | 1 | Parallel detection fault pulse |
| page_evt | input | 1 | New link code word stored pulse |
| lp_np_bit | input | 1 | Next-page bit of the code word being stored |
| flp_evt | input | 1 | Valid fast link pulse bursts seen pulse |

## Verification
The hardest situation to reach from the ports is the collision of an event with the read that would clear the bit. If the event is lost there, nothing is visible until a later read. The stimulus pulses fault_evt and page_evt in the very cycle of a read at index 6, both on a bit that is already set and on one that is clear. A second read follows at once, so the retained bit must show up there. Restart is likewise collided with events and with a read, which checks that restart has priority and that the read still returns the prior value.

// File: rtl/anx_pkg.sv
package anx_pkg;
   // Bit positions of the status word; a management reader decodes these.
   localparam int unsigned BIT_ABLE    = 0;
   localparam int unsigned BIT_PAGE    = 1;
   localparam int unsigned BIT_NP_LOC  = 2;
   localparam int unsigned BIT_NP_LP   = 3;
   localparam int unsigned BIT_FAULT   = 4;
   localparam int unsigned USED_BITS   = 5;

   typedef struct packed {
      logic fault;
      logic np_lp;
      logic np_loc;
      logic page;
      logic able;
   } anx_stat_t;
endpackage

// File: rtl/anx_sticky_bit.sv
// One status flag that is set by an event and cleared by restart, reset
// or, when CLEAR_ON_READ is set, a read that hits this register.
module anx_sticky_bit #(
   parameter bit CLEAR_ON_READ = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic restart_i,
   input  logic set_i,
   input  logic rd_hit_i,
   output logic q_o
);
   logic clr_by_read;

   generate
      if (CLEAR_ON_READ) begin : g_cor
         assign clr_by_read = rd_hit_i;
      end else begin : g_keep
         assign clr_by_read = 1'b0 & rd_hit_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || restart_i) begin
         q_o <= 1'b0;
      end else if (set_i) begin
         q_o <= 1'b1;
      end else if (clr_by_read) begin
         q_o <= 1'b0;
      end
   end

   // R8: an event colliding with a clearing read leaves the flag set
   a_r8_event_kept: assert property (@(posedge clk) disable iff (rst)
      (set_i && !restart_i) |=> q_o);

   // R9: restart leaves the flag clear whatever else happens
   a_r9_restart_clears: assert property (@(posedge clk) disable iff (rst)
      restart_i |=> !q_o);
endmodule

// File: rtl/anx_np_capture.sv
// Holds the partner next-page bit taken from the last stored code word.
module anx_np_capture (
   input  logic clk,
   input  logic rst,
   input  logic restart_i,
   input  logic load_i,
   input  logic np_i,
   output logic q_o
);
   always_ff @(posedge clk) begin
      if (rst || restart_i) begin
         q_o <= 1'b0;
      end else if (load_i) begin
         q_o <= np_i;
      end
   end

   // R6: the value follows the code word when one is stored
   a_r6_np_follows: assert property (@(posedge clk) disable iff (rst)
      (load_i && !restart_i) |=> (q_o == $past(np_i)));

   // R6: without a new code word the value holds
   a_r6_np_holds: assert property (@(posedge clk) disable iff (rst)
      (!load_i && !restart_i) |=> $stable(q_o));
endmodule

// File: rtl/anx_rd_port.sv
// Address decode and registered read data for one management register.
module anx_rd_port #(
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned REG_INDEX = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] word_i,
   output logic              rd_hit_o,
   output logic [DATA_W-1:0] rd_data
);
   localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_INDEX);

   generate
      if (REG_INDEX >= (1 << ADDR_W)) begin : g_bad_index
         $error("anx_rd_port: REG_INDEX does not fit in ADDR_W bits");
      end
   endgenerate

   assign rd_hit_o = rd_en && (rd_addr == MY_ADDR);

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_data <= '0;
      end else if (rd_hit_o) begin
         rd_data <= word_i;
      end else begin
         rd_data <= '0;
      end
   end

   // R1: a strobe to another index, or no strobe, yields zero
   a_r1_miss_zero: assert property (@(posedge clk) disable iff (rst)
      !(rd_en && (rd_addr == MY_ADDR)) |=> (rd_data == '0));

   // R1: a hit presents the word as it stood at the strobe
   a_r1_hit_value: assert property (@(posedge clk) disable iff (rst)
      rd_hit_o |=> (rd_data == $past(word_i)));
endmodule

// File: rtl/anx_status_reg.sv
module anx_status_reg #(
   parameter int unsigned ADDR_W        = 5,
   parameter int unsigned DATA_W        = 16,
   parameter int unsigned REG_INDEX     = 6,
   parameter bit          LOCAL_NP_CAP  = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              an_restart,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              fault_evt,
   input  logic              page_evt,
   input  logic              lp_np_bit,
   input  logic              flp_evt
);
   import anx_pkg::*;

   generate
      if (DATA_W < USED_BITS) begin : g_bad_width
         $error("anx_status_reg: DATA_W too small for the status fields");
      end
   endgenerate

   anx_stat_t         stat;
   logic              rd_hit;
   logic [DATA_W-1:0] word;

   anx_sticky_bit #(.CLEAR_ON_READ(1'b1)) u_fault (
      .clk(clk), .rst(rst), .restart_i(an_restart),
      .set_i(fault_evt), .rd_hit_i(rd_hit), .q_o(stat.fault));

   anx_sticky_bit #(.CLEAR_ON_READ(1'b1)) u_page (
      .clk(clk), .rst(rst), .restart_i(an_restart),
      .set_i(page_evt), .rd_hit_i(rd_hit), .q_o(stat.page));

   anx_sticky_bit #(.CLEAR_ON_READ(1'b0)) u_able (
      .clk(clk), .rst(rst), .restart_i(an_restart),
      .set_i(flp_evt), .rd_hit_i(rd_hit), .q_o(stat.able));

   anx_np_capture u_np (
      .clk(clk), .rst(rst), .restart_i(an_restart),
      .load_i(page_evt), .np_i(lp_np_bit), .q_o(stat.np_lp));

   generate
      if (LOCAL_NP_CAP) begin : g_np_yes
         assign stat.np_loc = 1'b1;
      end else begin : g_np_no
         assign stat.np_loc = 1'b0;
      end
   endgenerate

   always_comb begin
      word             = '0;
      word[BIT_FAULT]  = stat.fault;
      word[BIT_NP_LP]  = stat.np_lp;
      word[BIT_NP_LOC] = stat.np_loc;
      word[BIT_PAGE]   = stat.page;
      word[BIT_ABLE]   = stat.able;
   end

   anx_rd_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_INDEX(REG_INDEX)) u_rd (
      .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
      .word_i(word), .rd_hit_o(rd_hit), .rd_data(rd_data));

   // R2: reserved upper bits never show up
   a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
      rd_data[DATA_W-1:USED_BITS] == '0);

   // R3: local capability bit is present in every hit read
   a_r3_local_np: assert property (@(posedge clk) disable iff (rst)
      rd_hit |=> (rd_data[BIT_NP_LOC] == LOCAL_NP_CAP));

   // R7: auto-negotiation-able survives reads until a restart
   a_r7_able_sticky: assert property (@(posedge clk) disable iff (rst)
      (stat.able && !an_restart) |=> stat.able);

   // R4: a set fault flag survives anything but a hit read or restart
   a_r4_fault_holds: assert property (@(posedge clk) disable iff (rst)
      (stat.fault && !(rd_en && rd_addr == ADDR_W'(REG_INDEX)) && !an_restart)
      |=> stat.fault);
endmodule

// File: tb/anx_status_reg_tb.sv
module anx_status_reg_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        an_restart = 1'b0;
   logic        rd_en = 1'b0;
   logic [4:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        fault_evt = 1'b0;
   logic        page_evt = 1'b0;
   logic        lp_np_bit = 1'b0;
   logic        flp_evt = 1'b0;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // reference state
   bit m_fault, m_page, m_np, m_able;

   always #4 clk = ~clk;   // 125 MHz

   anx_status_reg u_dut (
      .clk(clk), .rst(rst), .an_restart(an_restart), .rd_en(rd_en),
      .rd_addr(rd_addr), .rd_data(rd_data), .fault_evt(fault_evt),
      .page_evt(page_evt), .lp_np_bit(lp_np_bit), .flp_evt(flp_evt));

   task automatic check(input logic [15:0] exp, input string tag);
      n_cmp++;
      if (rd_data !== exp) begin
         n_bad++;
         $display("FAIL %s: rd_data=%h expected=%h", tag, rd_data, exp);
      end
   endtask

   // One clock: apply inputs, advance the model, compare after the edge.
   task automatic step(input bit rd, input logic [4:0] a, input bit f,
                       input bit p, input bit np, input bit flp,
                       input bit rs, input string tag);
      logic [15:0] cur, exp;
      bit hit;
      rd_en = rd; rd_addr = a; fault_evt = f; page_evt = p;
      lp_np_bit = np; flp_evt = flp; an_restart = rs;
      @(posedge clk);
      cur = {11'd0, m_fault, m_np, 1'b1, m_page, m_able};
      hit = rd && (a == 5'd6);
      exp = hit ? cur : 16'h0000;
      if (rs) begin
         m_fault = 0; m_page = 0; m_np = 0; m_able = 0;
      end else begin
         m_fault = f | (m_fault & !hit);
         m_page  = p | (m_page & !hit);
         if (p) m_np = np;
         m_able  = m_able | flp;
      end
      @(negedge clk);
      check(exp, tag);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(0, 5'd0, 0, 0, 0, 0, 0, tag);
   endtask

   task automatic rd6(input string tag);
      step(1, 5'd6, 0, 0, 0, 0, 0, tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(16'h0000, "R10 during reset");
      rst = 1'b0;
      rd6("R10 first read after reset");
      idle(1, "R10 result 0x0004");

      // R4: single fault pulse held across idle and foreign reads
      step(0, 5'd0, 1, 0, 0, 0, 0, "R4 pulse");
      idle(6, "R4 idle");
      step(1, 5'd5, 0, 0, 0, 0, 0, "R1 other address");
      step(1, 5'd7, 0, 0, 0, 0, 0, "R1 other address zero");
      rd6("R4 first read");
      rd6("R4 read shows set");
      idle(1, "R4 second read shows clear");

      // R5 and R6: page with next-page bit
      step(0, 5'd0, 0, 1, 1, 0, 0, "R6 page np=1");
      idle(3, "R5 idle");
      rd6("R5 read");
      rd6("R5 set then clear");
      idle(1, "R6 np kept after read");
      step(0, 5'd0, 0, 1, 0, 0, 0, "R6 page np=0");
      rd6("R6 np follows");
      idle(1, "R6 np=0 read");

      // R7: able bit sticky across reads
      step(0, 5'd0, 0, 0, 0, 1, 0, "R7 flp");
      rd6("R7 read");
      rd6("R7 still set");
      idle(1, "R7 check");

      // R8: collisions with clearing read
      step(0, 5'd0, 1, 0, 0, 0, 0, "R8 prime fault");
      step(1, 5'd6, 1, 0, 0, 0, 0, "R8 fault collides set");
      step(1, 5'd6, 0, 1, 1, 0, 0, "R8 fault kept, page collides clear");
      rd6("R8 page kept");
      idle(1, "R8 all cleared");

      // R9: restart colliding with events and a read
      step(0, 5'd0, 1, 1, 1, 1, 0, "R9 load all");
      step(1, 5'd6, 1, 1, 1, 1, 1, "R9 restart with events and read");
      rd6("R9 read returns prior");
      idle(1, "R9 cleared, R3 bit2 kept");

      // R2: reserved bits with every flag set
      step(0, 5'd0, 1, 1, 1, 1, 0, "R2 load all");
      rd6("R2 read");
      idle(2, "R2 reserved zero");

      // R10: reset clears state
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(16'h0000, "R10 in second reset");
      rst = 1'b0;
      m_fault = 0; m_page = 0; m_np = 0; m_able = 0;
      rd6("R10 read after reset");
      idle(1, "R10 value 0x0004");

      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 20000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule